// File: doc/BRIEF.md
# Integrate-and-Dump Accumulator Bank

This block sums correlated samples for one receiver channel. Each accepted sample carries four signed products: in-phase and quadrature for a prompt arm, and in-phase and quadrature for a tracking arm. Each product is sign-extended and added into its own accumulator.

A dump strobe closes the integration interval. All four sums are copied together into result registers, the accumulators restart, a new-data flag is set, and a one-cycle interrupt pulse is raised. The result registers can be read at any time through a simple address-select read port. They have no overwrite protection: software should read all four soon after the interrupt. Software should trust a set only while the new-data flag is high. Reading the status word clears the flag.

Samples enter on a valid/ready stream. Ready is low during reset and stays high at all other times, so the block never applies back-pressure. A sample counts only in a cycle where both valid and ready are high. The caller keeps each interval at or below `MAX_LEN` accepted samples of `PROD_W`-bit products. The result width then always holds the sum, and no saturation logic is needed. A sample that arrives in the same cycle as a dump opens the new interval. Because of this, a dump issued just after a code change still reports the interval summed under the previous code.

Top module: `iad_dump_bank`

## Requirements
- R1: While reset is asserted, `s_ready` and `irq` are 0 and every read address returns 0. After reset, the flag is 0 and all results are 0.
- R2: After reset `s_ready` is 1. A sample is taken only when `s_valid` and `s_ready` are both 1. Cycles with `s_valid` low leave the sums unchanged.
- R3: Each arm adds its sign-extended `PROD_W`-bit product. Intervals of up to `MAX_LEN` samples, including all-minimum or all-maximum products, give exact two's-complement results in `RES_W` bits.
- R4: A dump sampled at clock edge k makes all four sums of the closed interval readable from the cycle after edge k. The accumulators then restart.
- R5: A sample accepted in the same cycle as a dump is counted in the new interval only.
- R6: `irq` is high for exactly the one cycle after each dump edge. Dumps on consecutive edges give consecutive pulses.
- R7: The flag is status bit 0. A dump sets it. A status read clears it: `rd_en` high with `rd_addr` = 4 at a clock edge. When a dump and a status read fall on the same edge, the flag stays set.
- R8: The read map is: address 0 = I prompt, 1 = Q prompt, 2 = I track, 3 = Q track, 4 = status (bit 0 = flag, other bits 0). Addresses 5 to 7 read 0. `rd_en` at addresses 0 to 3 does not clear the flag.
- R9: A dump that closes an interval with no accepted samples yields all-zero results.
- R10: A dump overwrites the results even while the flag is still set from the previous dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready (1 outside reset) |
| s_prod_ip | input | PROD_W | Prompt in-phase product, signed |
| s_prod_qp | input | PROD_W | Prompt quadrature product, signed |
| s_prod_it | input | PROD_W | Tracking in-phase product, signed |
| s_prod_qt | input | PROD_W | Tracking quadrature product, signed |
| dump | input | 1 | End-of-interval strobe |
| irq | output | 1 | One-cycle accumulation interrupt |
| rd_en | input | 1 | Read strobe (clears the flag at address 4) |
| rd_addr | input | 3 | Read address select |
| rd_data | output | RES_W | Read data |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a sample accepted on the dump edge. The bench drives a valid sample together with the strobe. It checks that the latched set excludes that sample and that the next set includes it.

The second pair is a status read on a dump edge. The bench issues two dumps on consecutive edges while the monitor clears the flag right after the first interrupt. It expects the flag to read 1 after the second edge, and 0 only after a later clear with no dump.

// File: rtl/iad_pkg.sv
`timescale 1ns/1ps
package iad_pkg;
  localparam int ARM_CNT  = 4;
  localparam int ADDR_W   = 3;
  localparam int FLAG_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    SEL_I_PROMPT = 3'd0,
    SEL_Q_PROMPT = 3'd1,
    SEL_I_TRACK  = 3'd2,
    SEL_Q_TRACK  = 3'd3,
    SEL_STATUS   = 3'd4
  } rd_sel_e;
endpackage

// File: rtl/iad_arm_acc.sv
`timescale 1ns/1ps
// One integrate-and-dump accumulator; a sample on the dump edge seeds the next interval.
module iad_arm_acc #(
  parameter int PROD_W = 8,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              dump,
  input  logic [PROD_W-1:0] prod,
  output logic [RES_W-1:0]  acc
);
  localparam int EXT_W = RES_W - PROD_W;

  logic [RES_W-1:0] prod_ext;
  assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (dump)  acc <= take ? prod_ext : '0;
    else if (take)  acc <= acc + prod_ext;
  end
endmodule

// File: rtl/iad_result_bank.sv
`timescale 1ns/1ps
// Result registers loaded together on dump, plus the interrupt pulse.
module iad_result_bank
  import iad_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           dump,
  input  logic [ARM_CNT-1:0][RES_W-1:0]  acc_in,
  output logic [ARM_CNT-1:0][RES_W-1:0]  res,
  output logic                           irq
);
  for (genvar g = 0; g < ARM_CNT; g++) begin : g_arm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    res[g] <= '0;
      else if (dump) res[g] <= acc_in[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= dump;
  end
endmodule

// File: rtl/iad_status_flag.sv
`timescale 1ns/1ps
// New-data flag: set by dump, cleared by a status read, dump wins a tie.
module iad_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic dump,
  input  logic clear,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (dump)  flag <= 1'b1;
    else if (clear) flag <= 1'b0;
  end
endmodule

// File: rtl/iad_read_port.sv
`timescale 1ns/1ps
// Address-select read mux; flags the status read that clears new data.
module iad_read_port
  import iad_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [ARM_CNT-1:0][RES_W-1:0] res,
  input  logic                          flag,
  output logic [RES_W-1:0]              rd_data,
  output logic                          status_rd
);
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < ARM_CNT; k++) begin
      if (rd_addr == ADDR_W'(k)) rd_data = res[k];
    end
    if (rd_addr == SEL_STATUS) rd_data[FLAG_BIT] = flag;
  end

  assign status_rd = rd_en && (rd_addr == SEL_STATUS);
endmodule

// File: rtl/iad_dump_bank.sv
`timescale 1ns/1ps
// Integrate-and-dump bank for the prompt and tracking arms of one channel.
module iad_dump_bank
  import iad_pkg::*;
#(
  parameter int PROD_W  = 8,
  parameter int RES_W   = 16,
  parameter int MAX_LEN = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PROD_W-1:0] s_prod_ip,
  input  logic [PROD_W-1:0] s_prod_qp,
  input  logic [PROD_W-1:0] s_prod_it,
  input  logic [PROD_W-1:0] s_prod_qt,
  input  logic              dump,
  output logic              irq,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [RES_W-1:0]  rd_data
);
  logic                          ready_q;
  logic                          take;
  logic                          status_rd;
  logic                          new_flag;
  logic [ARM_CNT-1:0][PROD_W-1:0] prod_bus;
  logic [ARM_CNT-1:0][RES_W-1:0]  acc_bus;
  logic [ARM_CNT-1:0][RES_W-1:0]  res_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign s_ready = ready_q;
  assign take    = s_valid && ready_q;

  // Arm order matches read addresses 0..3.
  assign prod_bus[0] = s_prod_ip;
  assign prod_bus[1] = s_prod_qp;
  assign prod_bus[2] = s_prod_it;
  assign prod_bus[3] = s_prod_qt;

  for (genvar g = 0; g < ARM_CNT; g++) begin : g_acc
    iad_arm_acc #(.PROD_W(PROD_W), .RES_W(RES_W)) u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .take (take),
      .dump (dump),
      .prod (prod_bus[g]),
      .acc  (acc_bus[g])
    );
  end

  iad_result_bank #(.RES_W(RES_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .dump  (dump),
    .acc_in(acc_bus),
    .res   (res_bus),
    .irq   (irq)
  );

  iad_status_flag u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .dump (dump),
    .clear(status_rd),
    .flag (new_flag)
  );

  iad_read_port #(.RES_W(RES_W)) u_rd (
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .res      (res_bus),
    .flag     (new_flag),
    .rd_data  (rd_data),
    .status_rd(status_rd)
  );
endmodule

// File: rtl/iad_dump_bank_chk.sv
`timescale 1ns/1ps
module iad_dump_bank_chk
  import iad_pkg::*;
#(
  parameter int PROD_W  = 8,
  parameter int RES_W   = 16,
  parameter int MAX_LEN = 128
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           dump,
  input logic                           take,
  input logic                           status_rd,
  input logic                           irq,
  input logic                           flag,
  input logic [ARM_CNT-1:0][PROD_W-1:0] prod,
  input logic [ARM_CNT-1:0][RES_W-1:0]  acc,
  input logic [ARM_CNT-1:0][RES_W-1:0]  res
);
  localparam int CNT_W = $clog2(MAX_LEN + 2) + 1;

  logic [CNT_W-1:0] run_len;

  function automatic logic sum_fits(input logic [RES_W-1:0] a, input logic [PROD_W-1:0] p);
    logic [RES_W:0] w;
    w = {a[RES_W-1], a} + {{(RES_W + 1 - PROD_W){p[PROD_W-1]}}, p};
    return w[RES_W] == w[RES_W-1];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (dump) run_len <= CNT_W'(take);
    else if (take) run_len <= run_len + 1'b1;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      a_r3_interval_len: assert (run_len <= CNT_W'(MAX_LEN));
      for (int k = 0; k < ARM_CNT; k++) begin
        if (take && !dump) begin
          a_r3_no_overflow: assert (sum_fits(acc[k], prod[k]));
        end
      end
    end
  end

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !dump) |=> $stable(acc));
  a_r4_latch_all: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> (res == $past(acc)));
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (dump && !take) |=> (acc == '0));
  a_r5_seed_new: assert property (@(posedge clk) disable iff (!rst_n)
    (dump && take) |=> ($signed(acc[0]) == $signed($past(prod[0]))));
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !dump |=> !irq);
  a_r6_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> flag);
  a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !dump) |=> !flag);
endmodule

bind iad_dump_bank iad_dump_bank_chk #(
  .PROD_W(PROD_W), .RES_W(RES_W), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dump     (dump),
  .take     (take),
  .status_rd(status_rd),
  .irq      (irq),
  .flag     (new_flag),
  .prod     (prod_bus),
  .acc      (acc_bus),
  .res      (res_bus)
);

// File: tb/iad_dump_bank_test.sv
`timescale 1ns/1ps
module iad_dump_bank_test;
  import iad_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int PROD_W     = 8;
  localparam int RES_W      = 16;
  localparam int MAX_LEN    = 128;
  localparam int WATCHDOG   = 20000;

  typedef logic [ARM_CNT-1:0][RES_W-1:0] quad_t;

  logic              clk;
  logic              rst_n;
  logic              s_valid;
  logic              s_ready;
  logic [PROD_W-1:0] s_prod_ip, s_prod_qp, s_prod_it, s_prod_qt;
  logic              dump;
  logic              irq;
  logic              rd_en;
  logic [2:0]        rd_addr;
  logic [RES_W-1:0]  rd_data;

  quad_t exp_q[$];
  int    sums[ARM_CNT];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  bit    mon_en = 0;
  int    clr_mode = 1; // 0 none, 1 status read, 2 rd_en at a data address

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  iad_dump_bank #(.PROD_W(PROD_W), .RES_W(RES_W), .MAX_LEN(MAX_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_prod_ip(s_prod_ip), .s_prod_qp(s_prod_qp), .s_prod_it(s_prod_it),
    .s_prod_qt(s_prod_qt), .dump(dump), .irq(irq), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and updates the reference sums.
  task automatic step(input bit v, input int a, input int b, input int c, input int d, input bit dmp);
    int    p[ARM_CNT];
    bit    tk;
    quad_t item;
    p = '{a, b, c, d};
    s_valid   = v;
    s_prod_ip = PROD_W'(a);
    s_prod_qp = PROD_W'(b);
    s_prod_it = PROD_W'(c);
    s_prod_qt = PROD_W'(d);
    dump      = dmp;
    tk = v && (s_ready === 1'b1);
    if (dmp) begin
      for (int k = 0; k < ARM_CNT; k++) item[k] = RES_W'(sums[k]);
      exp_q.push_back(item);
      for (int k = 0; k < ARM_CNT; k++) sums[k] = tk ? p[k] : 0;
    end else if (tk) begin
      for (int k = 0; k < ARM_CNT; k++) sums[k] += p[k];
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  // Monitor: judges each edge from the stimulus the design saw at that edge.
  initial begin
    bit    edge_dump, edge_clr, exp_flag;
    quad_t item;
    exp_flag = 0;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      #2;
      if (mon_en) begin
        edge_dump = dump;
        edge_clr  = rd_en && (rd_addr == SEL_STATUS);
        if (edge_dump)     exp_flag = 1;
        else if (edge_clr) exp_flag = 0;
        check("R6", "irq pulse", longint'(irq), longint'(edge_dump));
        if (edge_dump) begin
          if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R4 unexpected dump: actual 1 expected 0");
          end else begin
            item = exp_q.pop_front();
            for (int k = 0; k < ARM_CNT; k++) begin
              rd_addr = 3'(k);
              #1;
              check("R4", "latched sum", longint'($signed(rd_data)), longint'($signed(item[k])));
            end
          end
        end
        rd_addr = SEL_STATUS;
        #1;
        check("R7", "status word", longint'(rd_data), longint'(exp_flag));
        rd_en   = edge_dump && (clr_mode != 0);
        rd_addr = (clr_mode == 2) ? SEL_I_PROMPT : SEL_STATUS;
      end
    end
  end

  initial begin
    rst_n = 0; s_valid = 0; dump = 0; rd_en = 0; rd_addr = 0;
    s_prod_ip = 0; s_prod_qp = 0; s_prod_it = 0; s_prod_qt = 0;
    for (int k = 0; k < ARM_CNT; k++) sums[k] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "ready in reset", longint'(s_ready), 0);
    check("R1", "irq in reset", longint'(irq), 0);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      check("R1", "read in reset", longint'(rd_data), 0);
    end
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2", "ready after reset", longint'(s_ready), 1);
    mon_en = 1;
    idle(2);

    // R2/R3/R4: mixed samples, an invalid cycle ignored
    step(1, 3, -4, 5, -6, 0);
    step(0, 100, 100, 100, 100, 0);
    step(1, -7, 2, 0, 9, 0);
    step(1, 127, -128, 1, -1, 0);
    step(0, 0, 0, 0, 0, 1);
    idle(3);

    // R5: sample on the dump edge goes to the new interval
    step(1, 10, 20, 30, 40, 0);
    step(1, -5, 6, -7, 8, 1);
    step(1, 1, 1, 1, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    // R9 and R6/R7: back-to-back dump, empty interval, clear collides with dump
    step(0, 0, 0, 0, 0, 1);
    idle(3);

    // R8: rd_en at a data address leaves the flag set
    clr_mode = 2;
    step(1, 2, 2, 2, 2, 0);
    step(0, 0, 0, 0, 0, 1);
    idle(3);
    // R10: dump overwrites while the flag is still set
    step(1, -3, 4, -5, 6, 0);
    step(0, 0, 0, 0, 0, 1);
    clr_mode = 1;
    idle(3);

    // R3: longest interval with extreme products
    for (int i = 0; i < MAX_LEN; i++)
      step(1, -128, 127, (i % 2 == 0) ? 127 : -128, -128, 0);
    step(0, 0, 0, 0, 0, 1);
    idle(3);

    // R8: unused addresses read zero with results present
    mon_en = 0;
    @(negedge clk);
    for (int a = 5; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      check("R8", "unused address", longint'(rd_data), 0);
    end
    rd_addr = SEL_I_PROMPT;
    #1;
    check("R3", "min run I prompt", longint'($signed(rd_data)), -16384);
    check("R4", "pending dumps", longint'(exp_q.size()), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule